// File: doc/BRIEF.md
# Measurement Result Buffer with DMA Request

This block sits between an analog measurement chain and one DMA channel. It collects results from one of four producers, selected by a 3-bit field, and keeps them in an eight-entry queue of 18-bit words. Whenever the queue holds data and both enable bits are set, it raises a DMA request. The DMA engine takes the word at the head of the queue in every cycle in which it acknowledges.

A DFT result reaches the queue as two entries: the real part goes in first, and the imaginary part follows in the next cycle. The 16-bit results are widened with zeros. A ten-bit transfer counter counts the words the DMA engine removes. When that count equals the programmed total, a done interrupt is raised, and it holds until it is cleared.

Writes that cannot fit are dropped and recorded in a sticky overflow flag. Turning the buffer off empties it.

Top module: `afe_result_fifo`

## Requirements
- R1: The queue holds up to 8 entries. `dma_req` is high exactly when `ctrl_fifo_en` and `ctrl_req_en` are both 1 and the queue is not empty. After reset, `dma_req`, `done_irq` and `ovf_flag` are 0.
- R2: `ctrl_src_sel` picks the producer: 0 = sinc3 result, 1 = DFT result, 2 = sinc2/low-pass result, 3 = mean result. Codes 4 to 7 pick no producer. Only the strobe of the selected producer writes, and strobes of unselected producers have no effect.
- R3: A 16-bit result is stored as an 18-bit word with bits 17:16 equal to zero.
- R4: An accepted DFT strobe stores `dft_re` in that cycle and `dft_im` in the next cycle, so the real part leaves first. The strobe is accepted only when at least 2 entries are free at the start of the cycle. Otherwise both parts are dropped and the overflow flag is set.
- R5: A write that arrives while the queue holds 8 entries is dropped and sets `ovf_flag`. The flag stays set until `ctrl_fifo_en` is 0 for a cycle. Fullness is judged at the start of the cycle, so a pop in the same cycle does not make room.
- R6: While `ctrl_fifo_en` is 0, the queue is emptied, a pending imaginary part is discarded, no writes are taken and `dma_req` is 0.
- R7: While `ctrl_req_en` is 0, `dma_req` is 0 and `dma_ack` is ignored. Stored entries are kept and come out in order once requests are enabled again.
- R8: A cycle with `dma_ack` and `dma_req` both high removes the head entry, and `dma_data` always shows the oldest entry. A write and a removal in the same cycle leave the entry count unchanged and keep the order.
- R9: Each removed entry advances the transfer counter. `done_irq` rises in the cycle after the removal that brings the count to `xfer_count`, and it then stays high. A count of 0 never raises it.
- R10: `done_clr` clears `done_irq` and the transfer counter. If a removal happens in the same cycle, the clear wins and that removal is not counted.
- R11: A selected strobe that arrives in the cycle in which a pending imaginary part is being written is dropped and sets `ovf_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_src_sel | input | 3 | Producer select (0 sinc3, 1 DFT, 2 low-pass, 3 mean) |
| ctrl_fifo_en | input | 1 | Buffer enable; 0 empties the queue |
| ctrl_req_en | input | 1 | DMA request enable |
| xfer_count | input | 10 | Number of words to remove before done |
| done_clr | input | 1 | Clears done and the transfer counter |
| sinc3_vld | input | 1 | sinc3 result strobe |
| sinc3_dat | input | 16 | sinc3 result |
| dft_vld | input | 1 | DFT result strobe |
| dft_re | input | 18 | DFT real part |
| dft_im | input | 18 | DFT imaginary part |
| lpf_vld | input | 1 | sinc2/low-pass result strobe |
| lpf_dat | input | 16 | sinc2/low-pass result |
| mean_vld | input | 1 | Mean result strobe |
| mean_dat | input | 16 | Mean result |
| dma_ack | input | 1 | DMA takes the head entry |
| dma_req | output | 1 | DMA request |
| dma_data | output | 18 | Head entry of the queue |
| done_irq | output | 1 | Transfer-complete interrupt |
| ovf_flag | output | 1 | Sticky dropped-write flag |

## Verification
Two functions can meet in one cycle: a producer write and a DMA removal. The bench raises a sinc3 strobe in the same cycle as an acknowledge while the queue holds two entries. It then judges the result by the order of the words that come out and by `dma_req` going low after exactly three pops. The transfer-count clear can also coincide with a removal. That case is judged by `done_irq` staying low after the shared cycle and rising only after one further pop with a target of one.

// File: rtl/afe_fifo_pkg.sv
package afe_fifo_pkg;

    localparam int ENTRY_W  = 18;
    localparam int SAMPLE_W = 16;
    localparam int SEL_W    = 3;
    localparam int XFER_W   = 10;

    typedef enum logic [SEL_W-1:0] {
        SRC_SINC3 = 3'd0,
        SRC_DFT   = 3'd1,
        SRC_LPF   = 3'd2,
        SRC_MEAN  = 3'd3
    } src_sel_e;

    typedef logic [ENTRY_W-1:0] entry_t;

    typedef struct packed {
        logic   valid;
        entry_t data;
    } wr_req_t;

    function automatic entry_t widen(input logic [SAMPLE_W-1:0] s);
        return {{(ENTRY_W-SAMPLE_W){1'b0}}, s};
    endfunction

endpackage

// File: rtl/afe_src_select.sv
module afe_src_select
    import afe_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH+1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                fifo_en,
    input  logic [SEL_W-1:0]    sel,
    input  logic                sinc3_vld,
    input  logic [SAMPLE_W-1:0] sinc3_dat,
    input  logic                dft_vld,
    input  entry_t              dft_re,
    input  entry_t              dft_im,
    input  logic                lpf_vld,
    input  logic [SAMPLE_W-1:0] lpf_dat,
    input  logic                mean_vld,
    input  logic [SAMPLE_W-1:0] mean_dat,
    input  logic [CNT_W-1:0]    fill,
    output wr_req_t             wr,
    output logic                ovf
);

    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] PAIR_LVL = CNT_W'(DEPTH-2);

    src_sel_e            sel_e;
    logic                single_vld;
    logic [SAMPLE_W-1:0] single_dat;
    logic                dft_hit;
    logic                take_pair;
    logic                ovf_set;
    logic                pend_q;
    entry_t              imag_q;

    always_comb begin
        sel_e      = src_sel_e'(sel);
        single_vld = 1'b0;
        single_dat = '0;
        case (sel_e)
            SRC_SINC3: begin single_vld = sinc3_vld; single_dat = sinc3_dat; end
            SRC_LPF:   begin single_vld = lpf_vld;   single_dat = lpf_dat;   end
            SRC_MEAN:  begin single_vld = mean_vld;  single_dat = mean_dat;  end
            default:   ;
        endcase
        dft_hit = (sel_e == SRC_DFT) && dft_vld;
    end

    // Write arbitration: pending imaginary part first, then a new pair, then a single word
    always_comb begin
        wr        = '0;
        take_pair = 1'b0;
        ovf_set   = 1'b0;
        if (!fifo_en) begin
            wr = '0;
        end else if (pend_q) begin
            wr.valid = 1'b1;
            wr.data  = imag_q;
            ovf_set  = single_vld | dft_hit;
        end else if (dft_hit) begin
            if (fill <= PAIR_LVL) begin
                wr.valid  = 1'b1;
                wr.data   = dft_re;
                take_pair = 1'b1;
            end else begin
                ovf_set = 1'b1;
            end
        end else if (single_vld) begin
            if (fill < FULL_LVL) begin
                wr.valid = 1'b1;
                wr.data  = widen(single_dat);
            end else begin
                ovf_set = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !fifo_en) begin
            pend_q <= 1'b0;
            imag_q <= '0;
            ovf    <= 1'b0;
        end else begin
            pend_q <= take_pair;
            if (take_pair) imag_q <= dft_im;
            if (ovf_set)   ovf    <= 1'b1;
        end
    end

    p_imag_follows_r4: assert property (@(posedge clk) disable iff (rst)
        take_pair |=> (!fifo_en || (wr.valid && wr.data == $past(dft_im))));

    p_ovf_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (ovf && fifo_en) |=> ovf);

    p_pending_clash_r11: assert property (@(posedge clk) disable iff (rst)
        (pend_q && fifo_en && (single_vld || dft_hit)) |=> ovf);

endmodule

// File: rtl/afe_word_fifo.sv
module afe_word_fifo
    import afe_fifo_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH+1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  wr_req_t          wr,
    input  logic             rd_en,
    output entry_t           head,
    output logic [CNT_W-1:0] fill
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH-1);

    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == LAST) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (wr.valid && !rst && !flush) mem[wr_ptr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (wr.valid) wr_ptr <= step(wr_ptr);
            if (rd_en)    rd_ptr <= step(rd_ptr);
            case ({wr.valid, rd_en})
                2'b10:   fill <= fill + CNT_W'(1);
                2'b01:   fill <= fill - CNT_W'(1);
                default: fill <= fill;
            endcase
        end
    end

    assign head = mem[rd_ptr];

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst || flush)
        wr.valid |-> (fill < CNT_W'(DEPTH)));

    p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst || flush)
        rd_en |-> (fill != '0));

    p_push_pop_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (wr.valid && rd_en && !flush) |=> (fill == $past(fill)));

endmodule

// File: rtl/afe_xfer_tally.sv
module afe_xfer_tally
    import afe_fifo_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              pop,
    input  logic [XFER_W-1:0] target,
    input  logic              clr,
    output logic              done
);

    logic [XFER_W-1:0] cnt;
    logic [XFER_W-1:0] cnt_n;

    assign cnt_n = cnt + XFER_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt  <= '0;
            done <= 1'b0;
        end else if (pop && !done) begin
            cnt <= cnt_n;
            if (target != '0 && cnt_n == target) done <= 1'b1;
        end
    end

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (rst)
        clr |=> !done);

    p_done_after_pop_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(pop));

    p_done_holds_r9: assert property (@(posedge clk) disable iff (rst)
        (done && !clr) |=> done);

endmodule

// File: rtl/afe_result_fifo.sv
module afe_result_fifo
    import afe_fifo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [SEL_W-1:0]    ctrl_src_sel,
    input  logic                ctrl_fifo_en,
    input  logic                ctrl_req_en,
    input  logic [XFER_W-1:0]   xfer_count,
    input  logic                done_clr,
    input  logic                sinc3_vld,
    input  logic [SAMPLE_W-1:0] sinc3_dat,
    input  logic                dft_vld,
    input  logic [ENTRY_W-1:0]  dft_re,
    input  logic [ENTRY_W-1:0]  dft_im,
    input  logic                lpf_vld,
    input  logic [SAMPLE_W-1:0] lpf_dat,
    input  logic                mean_vld,
    input  logic [SAMPLE_W-1:0] mean_dat,
    input  logic                dma_ack,
    output logic                dma_req,
    output logic [ENTRY_W-1:0]  dma_data,
    output logic                done_irq,
    output logic                ovf_flag
);

    localparam int CNT_W = $clog2(DEPTH+1);

    wr_req_t          wr;
    logic [CNT_W-1:0] fill;
    logic             pop;
    entry_t           head;

    afe_src_select #(.DEPTH(DEPTH), .CNT_W(CNT_W)) sel_i (
        .clk       (clk),
        .rst       (rst),
        .fifo_en   (ctrl_fifo_en),
        .sel       (ctrl_src_sel),
        .sinc3_vld (sinc3_vld),
        .sinc3_dat (sinc3_dat),
        .dft_vld   (dft_vld),
        .dft_re    (dft_re),
        .dft_im    (dft_im),
        .lpf_vld   (lpf_vld),
        .lpf_dat   (lpf_dat),
        .mean_vld  (mean_vld),
        .mean_dat  (mean_dat),
        .fill      (fill),
        .wr        (wr),
        .ovf       (ovf_flag)
    );

    afe_word_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W)) fifo_i (
        .clk   (clk),
        .rst   (rst),
        .flush (!ctrl_fifo_en),
        .wr    (wr),
        .rd_en (pop),
        .head  (head),
        .fill  (fill)
    );

    afe_xfer_tally tally_i (
        .clk    (clk),
        .rst    (rst),
        .pop    (pop),
        .target (xfer_count),
        .clr    (done_clr),
        .done   (done_irq)
    );

    assign dma_req  = ctrl_fifo_en && ctrl_req_en && (fill != '0);
    assign pop      = dma_req && dma_ack;
    assign dma_data = head;

    p_flush_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !ctrl_fifo_en |=> (fill == '0));

    p_ack_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_fifo_en && !ctrl_req_en && dma_ack) |=> (!ctrl_fifo_en || fill >= $past(fill)));

endmodule

// File: tb/afe_result_fifo_tb_top.sv
module afe_result_fifo_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  ctrl_src_sel;
    logic        ctrl_fifo_en, ctrl_req_en;
    logic [9:0]  xfer_count;
    logic        done_clr;
    logic        sinc3_vld, dft_vld, lpf_vld, mean_vld;
    logic [15:0] sinc3_dat, lpf_dat, mean_dat;
    logic [17:0] dft_re, dft_im;
    logic        dma_ack;
    logic        dma_req;
    logic [17:0] dma_data;
    logic        done_irq, ovf_flag;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    afe_result_fifo dut_i (
        .clk(clk), .rst(rst), .ctrl_src_sel(ctrl_src_sel),
        .ctrl_fifo_en(ctrl_fifo_en), .ctrl_req_en(ctrl_req_en),
        .xfer_count(xfer_count), .done_clr(done_clr),
        .sinc3_vld(sinc3_vld), .sinc3_dat(sinc3_dat),
        .dft_vld(dft_vld), .dft_re(dft_re), .dft_im(dft_im),
        .lpf_vld(lpf_vld), .lpf_dat(lpf_dat),
        .mean_vld(mean_vld), .mean_dat(mean_dat),
        .dma_ack(dma_ack), .dma_req(dma_req), .dma_data(dma_data),
        .done_irq(done_irq), .ovf_flag(ovf_flag)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [15:0] d;
        logic [1:0]  n;
        logic [17:0] w0;
        logic [17:0] w1;
    } vec_t;

    // Every producer strobes at once: sinc3=d, lpf=d^00FF, mean=~d, re={11,d}, im={10,d}
    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 16'h1234, 2'd1, 18'h01234, 18'h00000},
        '{3'd1, 16'hABCD, 2'd2, 18'h3ABCD, 18'h2ABCD},
        '{3'd2, 16'h8001, 2'd1, 18'h080FE, 18'h00000},
        '{3'd3, 16'h00F0, 2'd1, 18'h0FF0F, 18'h00000},
        '{3'd4, 16'h5555, 2'd0, 18'h00000, 18'h00000},
        '{3'd7, 16'hAAAA, 2'd0, 18'h00000, 18'h00000},
        '{3'd3, 16'hFFFF, 2'd1, 18'h00000, 18'h00000},
        '{3'd0, 16'hFFFF, 2'd1, 18'h0FFFF, 18'h00000}
    };

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic pulse_all(input logic [15:0] d);
        sinc3_vld = 1; lpf_vld = 1; mean_vld = 1; dft_vld = 1;
        sinc3_dat = d; lpf_dat = d ^ 16'h00FF; mean_dat = ~d;
        dft_re = {2'b11, d}; dft_im = {2'b10, d};
        cyc();
        sinc3_vld = 0; lpf_vld = 0; mean_vld = 0; dft_vld = 0;
    endtask

    task automatic push1(input logic [15:0] d);
        sinc3_vld = 1; sinc3_dat = d;
        cyc();
        sinc3_vld = 0;
    endtask

    task automatic pop_chk(input string tag, input logic [17:0] exp);
        chk(tag, {14'd0, dma_data}, {14'd0, exp});
        dma_ack = 1;
        cyc();
        dma_ack = 0;
    endtask

    task automatic flush();
        ctrl_fifo_en = 0;
        cyc();
        ctrl_fifo_en = 1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1; ctrl_src_sel = 0; ctrl_fifo_en = 0; ctrl_req_en = 0;
        xfer_count = 0; done_clr = 0; dma_ack = 0;
        sinc3_vld = 0; dft_vld = 0; lpf_vld = 0; mean_vld = 0;
        sinc3_dat = 0; lpf_dat = 0; mean_dat = 0; dft_re = 0; dft_im = 0;
        repeat (3) cyc();
        rst = 0;
        cyc();
        chk("R1 reset req", {31'd0, dma_req}, 0);
        chk("R1 reset done", {31'd0, done_irq}, 0);
        chk("R1 reset ovf", {31'd0, ovf_flag}, 0);

        ctrl_fifo_en = 1; ctrl_req_en = 1;
        cyc();

        // Table walk: source select, widening, DFT ordering (R2 R3 R4), count 0 never done (R9)
        for (int i = 0; i < NV; i++) begin
            ctrl_src_sel = VECS[i].sel;
            pulse_all(VECS[i].d);
            cyc();
            chk("R2 req after strobe", {31'd0, dma_req}, {31'd0, VECS[i].n != 0});
            if (VECS[i].n >= 1) pop_chk("R3 first word", VECS[i].w0);
            if (VECS[i].n == 2) pop_chk("R4 imag second", VECS[i].w1);
            chk("R2 drained", {31'd0, dma_req}, 0);
        end
        chk("R9 zero count never done", {31'd0, done_irq}, 0);
        chk("R2 no overflow in walk", {31'd0, ovf_flag}, 0);

        // Fill to 8, overflow on the ninth (R1 R5 R8)
        ctrl_src_sel = 0;
        for (int i = 0; i < 8; i++) push1(16'h0100 + 16'(i));
        chk("R1 full no ovf", {31'd0, ovf_flag}, 0);
        push1(16'h0999);
        chk("R5 ovf on full", {31'd0, ovf_flag}, 1);
        for (int i = 0; i < 8; i++) pop_chk("R8 order", 18'h00100 + 18'(i));
        chk("R1 empty after 8", {31'd0, dma_req}, 0);
        chk("R5 ovf sticky", {31'd0, ovf_flag}, 1);
        flush();
        chk("R5 ovf cleared by disable", {31'd0, ovf_flag}, 0);

        // Flush and writes while disabled (R6)
        for (int i = 0; i < 3; i++) push1(16'h0200 + 16'(i));
        ctrl_fifo_en = 0;
        cyc();
        chk("R6 req low when disabled", {31'd0, dma_req}, 0);
        push1(16'h0777);
        ctrl_fifo_en = 1;
        cyc();
        chk("R6 empty after flush", {31'd0, dma_req}, 0);

        // Requests disabled (R7)
        ctrl_req_en = 0;
        push1(16'h0301); push1(16'h0302);
        chk("R7 no req", {31'd0, dma_req}, 0);
        dma_ack = 1; cyc(); dma_ack = 0;
        ctrl_req_en = 1;
        cyc();
        chk("R7 req back", {31'd0, dma_req}, 1);
        pop_chk("R7 kept first", 18'h00301);
        pop_chk("R7 kept second", 18'h00302);
        chk("R7 drained", {31'd0, dma_req}, 0);

        // DFT pair with only one free slot (R4)
        for (int i = 0; i < 7; i++) push1(16'h0400 + 16'(i));
        ctrl_src_sel = 1;
        dft_re = 18'h3F00F; dft_im = 18'h2F00F; dft_vld = 1; cyc(); dft_vld = 0;
        cyc();
        chk("R4 pair refused sets ovf", {31'd0, ovf_flag}, 1);
        for (int i = 0; i < 7; i++) pop_chk("R4 no partial pair", 18'h00400 + 18'(i));
        chk("R4 nothing after", {31'd0, dma_req}, 0);
        flush();

        // Strobe during pending imaginary cycle (R11)
        dft_re = 18'h11111; dft_im = 18'h22222; dft_vld = 1; cyc();
        dft_re = 18'h33333; dft_im = 18'h04444; cyc(); dft_vld = 0;
        cyc();
        chk("R11 clash ovf", {31'd0, ovf_flag}, 1);
        pop_chk("R11 real", 18'h11111);
        pop_chk("R11 imag", 18'h22222);
        chk("R11 second dropped", {31'd0, dma_req}, 0);
        flush();

        // Write and removal in the same cycle (R8)
        ctrl_src_sel = 0;
        push1(16'h0A0A); push1(16'h0B0B);
        sinc3_vld = 1; sinc3_dat = 16'h0C0C; dma_ack = 1;
        cyc();
        sinc3_vld = 0; dma_ack = 0;
        pop_chk("R8 same cycle order B", 18'h00B0B);
        pop_chk("R8 same cycle order C", 18'h00C0C);
        chk("R8 count kept", {31'd0, dma_req}, 0);

        // Done interrupt (R9 R10)
        done_clr = 1; cyc(); done_clr = 0;
        xfer_count = 10'd3;
        for (int i = 0; i < 4; i++) push1(16'h0500 + 16'(i));
        pop_chk("R9 pop1", 18'h00500);
        pop_chk("R9 pop2", 18'h00501);
        chk("R9 not yet", {31'd0, done_irq}, 0);
        pop_chk("R9 pop3", 18'h00502);
        chk("R9 done at count", {31'd0, done_irq}, 1);
        pop_chk("R9 pop4", 18'h00503);
        chk("R9 done held", {31'd0, done_irq}, 1);
        done_clr = 1; cyc(); done_clr = 0;
        chk("R10 cleared", {31'd0, done_irq}, 0);

        // Clear wins over a same-cycle removal (R10)
        xfer_count = 10'd1;
        push1(16'h0601); push1(16'h0602);
        dma_ack = 1; done_clr = 1; cyc(); dma_ack = 0; done_clr = 0;
        chk("R10 clear wins", {31'd0, done_irq}, 0);
        pop_chk("R10 next pop data", 18'h00602);
        chk("R10 counter restarted", {31'd0, done_irq}, 1);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule